// File: doc/BRIEF.md
# Two-Phase Audio Strobe Generator

This block derives the timing strobes for an audio unit from a system clock that ticks once per CPU half-cycle. It walks a short repeating sequence of half-cycle positions and, from that position, produces the two complementary CPU phase signals and three audio strobes. The first strobe has 25% duty. The second is an active-low strobe with 75% duty on the opposite phase. The third is the true-polarity copy of the second. Every strobe falls in a phase-1 half-cycle. Counters clocked by these strobes therefore never act in the phase-2 half-cycle, which is when the CPU writes.

Sequence position 0 is the half-cycle with phase 1 high and the first strobe high. Across the four positions 0, 1, 2, 3, the outputs are:

- `phi1`: 1, 0, 1, 0
- `strobe_a`: 1, 0, 0, 0
- `strobe_bn`: 1, 1, 0, 1
- `strobe_b`: 0, 0, 1, 0

A synchronous reset returns the sequence to position 0. An alignment input restarts the sequence at position 0 from any position, so the strobes can be locked to an outside phase reference.

Top module: `audio_strobe_gen`

## Requirements
- R1: `phi1` and `phi2` are complements at all times. The pair changes value on every clock edge, except when the edge restarts the sequence from position 0.
- R2: `strobe_a` is high at sequence position 0 only. From position 0 it follows the pattern 1,0,0,0 and repeats every four clocks. It is never high while `phi1` is low.
- R3: `strobe_bn` is low at sequence position 2 only. From position 0 it follows the pattern 1,1,0,1. It is low only in a half-cycle where `phi1` is high.
- R4: `strobe_b` is always the inverse of `strobe_bn`, and follows the pattern 0,0,1,0 from position 0.
- R5: In any half-cycle where `phi2` is high, `strobe_a` and `strobe_b` are both low and `strobe_bn` is high.
- R6: All outputs come straight from flip-flops. The sequence advances by exactly one position per clock edge and wraps from position 3 to position 0.
- R7: On any clock edge that samples `rst` high, the outputs take the position-0 pattern: `phi1`=1, `phi2`=0, `strobe_a`=1, `strobe_bn`=1, `strobe_b`=0. They hold that pattern while `rst` stays high. The first edge after release moves to position 1.
- R8: On a clock edge that samples `align` high, the outputs take the position-0 pattern, whatever the current position. The sequence continues from position 0. When `align` arrives at position 3, the result is the same as the natural wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one edge per CPU half-cycle |
| rst | input | 1 | Synchronous active-high reset to position 0 |
| align | input | 1 | Restart the sequence at position 0 on this edge |
| phi1 | output | 1 | CPU phase 1, high on even positions |
| phi2 | output | 1 | CPU phase 2, complement of phi1 |
| strobe_a | output | 1 | 25% duty audio strobe, high at position 0 |
| strobe_bn | output | 1 | Active-low 75% duty strobe, low at position 2 |
| strobe_b | output | 1 | True-polarity copy of strobe_bn |

## Verification
An alignment restart can land on the same edge as the natural wrap of the sequence. It can also land on the same edge as a synchronous reset. The bench raises `align` with the model sitting at each of the four positions in turn, and also as part of an irregular pattern that falls on every position. Once it raises `align` together with `rst`. In every case, the expected outputs come from a position count that the bench keeps by arithmetic: each edge increments it modulo four, and reset or align clears it. The five outputs are compared against that count after every edge.

// File: rtl/audio_clk_pkg.sv
package audio_clk_pkg;
  typedef struct packed {
    logic phi1;
    logic phi2;
    logic str_a;
    logic str_bn;
    logic str_b;
  } strobe_t;
endpackage

// File: rtl/phase_counter.sv
module phase_counter #(
  parameter int SEQ_LEN = 4,
  localparam int CW = $clog2(SEQ_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          align,
  output logic [CW-1:0] idx_next
);
  localparam logic [CW-1:0] LAST = CW'(SEQ_LEN - 1);

  logic [CW-1:0] idx;

  always_comb begin
    if (rst || align)     idx_next = '0;
    else if (idx == LAST) idx_next = '0;
    else                  idx_next = idx + CW'(1);
  end

  always_ff @(posedge clk) idx <= idx_next;
endmodule

// File: rtl/strobe_decode.sv
module strobe_decode
  import audio_clk_pkg::*;
#(
  parameter int SEQ_LEN = 4,
  localparam int CW = $clog2(SEQ_LEN)
) (
  input  logic [CW-1:0] idx,
  output strobe_t       s
);
  localparam logic [CW-1:0] MID = CW'(SEQ_LEN / 2);

  always_comb begin
    s.phi1   = ~idx[0];
    s.phi2   = idx[0];
    s.str_a  = (idx == '0);
    s.str_b  = (idx == MID);
    s.str_bn = ~(idx == MID);
  end
endmodule

// File: rtl/strobe_reg.sv
module strobe_reg
  import audio_clk_pkg::*;
(
  input  logic    clk,
  input  strobe_t d,
  output strobe_t q
);
  always_ff @(posedge clk) q <= d;
endmodule

// File: rtl/audio_strobe_gen.sv
module audio_strobe_gen
  import audio_clk_pkg::*;
#(
  parameter int SEQ_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic align,
  output logic phi1,
  output logic phi2,
  output logic strobe_a,
  output logic strobe_bn,
  output logic strobe_b
);
  localparam int CW = $clog2(SEQ_LEN);

  logic [CW-1:0] idx_next;
  strobe_t       dec;
  strobe_t       q;

  phase_counter #(.SEQ_LEN(SEQ_LEN)) u_cnt (
    .clk(clk), .rst(rst), .align(align), .idx_next(idx_next)
  );

  strobe_decode #(.SEQ_LEN(SEQ_LEN)) u_dec (
    .idx(idx_next), .s(dec)
  );

  strobe_reg u_reg (.clk(clk), .d(dec), .q(q));

  assign phi1      = q.phi1;
  assign phi2      = q.phi2;
  assign strobe_a  = q.str_a;
  assign strobe_bn = q.str_bn;
  assign strobe_b  = q.str_b;
endmodule

// File: rtl/audio_strobe_chk.sv
module audio_strobe_chk (
  input logic clk,
  input logic rst,
  input logic align,
  input logic phi1,
  input logic phi2,
  input logic strobe_a,
  input logic strobe_bn,
  input logic strobe_b
);
  p_phase_compl_r1: assert property (@(posedge clk) disable iff (rst)
    phi1 != phi2);
  p_phase_alt_r1: assert property (@(posedge clk) disable iff (rst)
    !align |=> phi1 != $past(phi1));
  p_a_in_phi1_r2: assert property (@(posedge clk) disable iff (rst)
    strobe_a |-> phi1);
  p_a_single_r2: assert property (@(posedge clk) disable iff (rst)
    (strobe_a && !align) |=> !strobe_a);
  p_bn_in_phi1_r3: assert property (@(posedge clk) disable iff (rst)
    !strobe_bn |-> phi1);
  p_b_inverse_r4: assert property (@(posedge clk) disable iff (rst)
    strobe_b != strobe_bn);
  p_quiet_phi2_r5: assert property (@(posedge clk) disable iff (rst)
    phi2 |-> (!strobe_a && !strobe_b && strobe_bn));
  p_one_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe_a, strobe_b}));
  p_align_restart_r8: assert property (@(posedge clk) disable iff (rst)
    align |=> (phi1 && strobe_a && strobe_bn));
endmodule

bind audio_strobe_gen audio_strobe_chk u_chk (
  .clk(clk), .rst(rst), .align(align), .phi1(phi1), .phi2(phi2),
  .strobe_a(strobe_a), .strobe_bn(strobe_bn), .strobe_b(strobe_b)
);

// File: tb/sim_audio_strobe_gen.sv
module sim_audio_strobe_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic align = 1'b0;
  logic phi1, phi2, strobe_a, strobe_bn, strobe_b;
  int checks = 0;
  int errors = 0;
  int pos = 0;
  bit done = 0;

  always #4 clk = ~clk;

  audio_strobe_gen u0 (
    .clk(clk), .rst(rst), .align(align), .phi1(phi1), .phi2(phi2),
    .strobe_a(strobe_a), .strobe_bn(strobe_bn), .strobe_b(strobe_b)
  );

  task automatic chk(input string req, input string sig, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at pos %0d: actual %b expected %b", req, sig, pos, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "phi1", phi1, pos % 2 == 0);
    chk(req, "phi2", phi2, pos % 2 == 1);
    chk(req, "strobe_a", strobe_a, pos == 0);
    chk(req, "strobe_bn", strobe_bn, pos != 2);
    chk(req, "strobe_b", strobe_b, pos == 2);
    if (phi2 === 1'b1) chk("R5", "quiet", strobe_a | strobe_b, 1'b0);
    chk("R4", "inverse", strobe_b, ~strobe_bn);
  endtask

  task automatic step(input logic r, input logic a);
    @(negedge clk);
    rst = r;
    align = a;
    @(posedge clk);
    if (r || a) pos = 0;
    else pos = (pos + 1) % 4;
    #1;
  endtask

  initial begin
    // R7: reset held across several edges
    repeat (3) begin
      step(1'b1, 1'b0);
      check_all("R7");
    end
    step(1'b0, 1'b0);
    check_all("R7");
    // R1 R2 R3 R6: free-running sequence
    for (int i = 0; i < 16; i++) begin
      step(1'b0, 1'b0);
      check_all("R6");
    end
    // R8: align at each position
    for (int k = 0; k < 4; k++) begin
      while (pos != k) begin
        step(1'b0, 1'b0);
        check_all("R2");
      end
      step(1'b0, 1'b1);
      check_all("R8");
      for (int j = 0; j < 5; j++) begin
        step(1'b0, 1'b0);
        check_all("R3");
      end
    end
    // R8: irregular align pattern
    for (int i = 0; i < 200; i++) begin
      step(1'b0, (i % 7 == 3) || (i % 11 == 5));
      check_all("R8");
    end
    // R7: reset together with align mid-run
    step(1'b0, 1'b0);
    step(1'b1, 1'b1);
    check_all("R7");
    step(1'b0, 1'b0);
    check_all("R1");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule